// File: doc/BRIEF.md
# Cache Maintenance Command Controller

This block sits between a register interface and the tag pipeline of a cache and turns software requests into maintenance commands. Two global operations are available: flush every dirty line to memory (evict-all) and drop every line (invalidate-all). Each is requested by setting a bit in a control word. A matching status bit reads 1 while that command is running in the cache. Invalidate-all is already requested when reset releases, so the cache starts out clean without any software action.

Single-line maintenance needs no separate start bit. Writing a line address into the evict-address register or the invalidate-address register launches the matching operation. One shared busy bit covers both kinds. While busy is set, further address writes are dropped. Software can therefore poll busy and write the next address once it clears.

The controller keeps at most one command outstanding toward the cache. Each command is a one-cycle strobe with an opcode and a line address, and the cache ends it with a one-cycle done pulse. An optional hold flag stalls ordinary cache traffic while a global operation is pending or running.

Top module: `cache_maint_ctrl`

## Requirements
- R1: While reset is asserted, the control word (offset 0x0C) reads 0x00010000, the busy word (offset 0x18) reads 0, and no command is issued.
- R2: After reset releases, the first command is invalidate-all (opcode 1, address 0). It is issued on the first clock edge with reset inactive. Control-word bit 20 reads 1 while it runs. Bits 16 and 20 both read 0 after the done pulse.
- R3: Writing 1 to control-word bit 0 requests evict-all (opcode 0, address 0). Bit 4 reads 1 while the command runs. Bits 0 and 4 both clear on the done pulse.
- R4: A write to offset 0x10 while not busy stores the address and issues an evict-line command (opcode 2) carrying that address. The command strobe appears one cycle after the write edge.
- R5: A write to offset 0x14 while not busy stores the address and issues an invalidate-line command (opcode 3) carrying that address.
- R6: Bit 0 of offset 0x18 reads 1 from the accepted address write until the done pulse of that line command, and 0 after it.
- R7: An address write to 0x10 or 0x14 while busy reads 1 is ignored. No further command is issued, and both stored addresses keep their values.
- R8: The command strobe lasts one cycle. No new strobe is issued while a command still awaits its done pulse.
- R9: When requests compete, evict-all is served before invalidate-all, and any global request is served before a pending line operation.
- R10: Output `txnHold` is 1 exactly when control-word bit 24 is 1 and a global request (bit 0 or bit 16) is pending.
- R11: Bits of the control word other than 0, 4, 16, 20 and 24 read 0, and writes to them have no effect. Writes to bits 4 and 20 have no effect either. Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | REG_AW | Byte offset of the write |
| regWrData | input | DATA_W | Write data |
| regRdAddr | input | REG_AW | Byte offset of the read |
| regRdData | output | DATA_W | Read data (combinational from regRdAddr) |
| cmdValid | output | 1 | One-cycle command strobe to the cache |
| cmdOp | output | 2 | Opcode: 0 evict-all, 1 invalidate-all, 2 evict-line, 3 invalidate-line |
| cmdAddr | output | LINE_W | Line address of the command (0 for global ops) |
| cmdDone | input | 1 | One-cycle completion pulse from the cache |
| txnHold | output | 1 | Stall request for normal cache transactions |

## Verification
The bench drives the block in several phases:
- The reset-time invalidate is held unacknowledged, which separates the pending state from the running state of a global status bit.
- A held evict-line command receives two address writes while busy. A design that queues or overwrites these, instead of dropping them, shows up as an extra command or a changed address readback.
- While one global command is held, a line write and an invalidate-all request are queued in reverse of their service order. This tells strict priority apart from arrival order.
- Writing the complement of the defined control bits separates real reserved-bit masking from a plain storage register.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  typedef enum logic [1:0] {
    OP_EVICT_ALL  = 2'd0,
    OP_INVAL_ALL  = 2'd1,
    OP_EVICT_LINE = 2'd2,
    OP_INVAL_LINE = 2'd3
  } cmoOp_t;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL      = 8'h0C;
  localparam logic [7:0] OFS_EVICT_ADR = 8'h10;
  localparam logic [7:0] OFS_INVAL_ADR = 8'h14;
  localparam logic [7:0] OFS_BUSY      = 8'h18;

  // control word bit positions
  localparam int BIT_EV_REQ  = 0;
  localparam int BIT_EV_STS  = 4;
  localparam int BIT_INV_REQ = 16;
  localparam int BIT_INV_STS = 20;
  localparam int BIT_HOLD    = 24;

  // strobes from control to datapath
  typedef struct packed {
    logic   capEvict;
    logic   capInval;
    logic   issue;
    cmoOp_t op;
  } ctlStrobe_t;

  // state exposed by control for readback
  typedef struct packed {
    logic evReq;
    logic evSts;
    logic invReq;
    logic invSts;
    logic holdEn;
    logic lineBusy;
  } ctlStatus_t;

endpackage

// File: rtl/cmo_control.sv
module cmo_control
  import cmo_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic              wrEvReqBit,
  input  logic              wrInvReqBit,
  input  logic              wrHoldBit,
  input  logic              cmdDone,
  output ctlStrobe_t        strobe,
  output ctlStatus_t        status,
  output logic              cmdValid,
  output cmoOp_t            cmdOp,
  output logic              txnHold
);

  logic evReq, evSts, invReq, invSts, holdEn;
  logic linePend, lineRun, lineIsInval;
  logic outstanding, cmdValidQ;
  cmoOp_t curOp, cmdOpQ, issueOp;

  logic wrCtrl, wrEvAdr, wrInvAdr, busy;
  logic acceptEv, acceptInv, issue, doneNow, issueLine;

  always_comb begin
    wrCtrl    = regWrEn && (regWrAddr == REG_AW'(OFS_CTRL));
    wrEvAdr   = regWrEn && (regWrAddr == REG_AW'(OFS_EVICT_ADR));
    wrInvAdr  = regWrEn && (regWrAddr == REG_AW'(OFS_INVAL_ADR));
    busy      = linePend || lineRun;
    acceptEv  = wrEvAdr && !busy;
    acceptInv = wrInvAdr && !busy;
    doneNow   = cmdDone && outstanding;
    issue     = !outstanding && (evReq || invReq || linePend);
    if (evReq)            issueOp = OP_EVICT_ALL;
    else if (invReq)      issueOp = OP_INVAL_ALL;
    else if (lineIsInval) issueOp = OP_INVAL_LINE;
    else                  issueOp = OP_EVICT_LINE;
    issueLine = issue && !evReq && !invReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evReq       <= 1'b0;
      evSts       <= 1'b0;
      invReq      <= 1'b1;
      invSts      <= 1'b0;
      holdEn      <= 1'b0;
      linePend    <= 1'b0;
      lineRun     <= 1'b0;
      lineIsInval <= 1'b0;
      outstanding <= 1'b0;
      cmdValidQ   <= 1'b0;
      curOp       <= OP_EVICT_ALL;
      cmdOpQ      <= OP_EVICT_ALL;
    end else begin
      cmdValidQ <= issue;
      if (issue) begin
        cmdOpQ      <= issueOp;
        curOp       <= issueOp;
        outstanding <= 1'b1;
      end else if (doneNow) begin
        outstanding <= 1'b0;
      end

      // evict-all request and status
      if (issue && issueOp == OP_EVICT_ALL) evSts <= 1'b1;
      else if (doneNow && curOp == OP_EVICT_ALL) evSts <= 1'b0;
      if (wrCtrl && wrEvReqBit) evReq <= 1'b1;
      else if (doneNow && curOp == OP_EVICT_ALL) evReq <= 1'b0;

      // invalidate-all request and status
      if (issue && issueOp == OP_INVAL_ALL) invSts <= 1'b1;
      else if (doneNow && curOp == OP_INVAL_ALL) invSts <= 1'b0;
      if (wrCtrl && wrInvReqBit) invReq <= 1'b1;
      else if (doneNow && curOp == OP_INVAL_ALL) invReq <= 1'b0;

      if (wrCtrl) holdEn <= wrHoldBit;

      // single-line tracking
      if (acceptEv || acceptInv) begin
        linePend    <= 1'b1;
        lineIsInval <= acceptInv;
      end else if (issueLine) begin
        linePend <= 1'b0;
      end
      if (issueLine) lineRun <= 1'b1;
      else if (doneNow && (curOp == OP_EVICT_LINE || curOp == OP_INVAL_LINE)) lineRun <= 1'b0;
    end
  end

  assign strobe.capEvict = acceptEv;
  assign strobe.capInval = acceptInv;
  assign strobe.issue    = issue;
  assign strobe.op       = issueOp;

  assign status.evReq    = evReq;
  assign status.evSts    = evSts;
  assign status.invReq   = invReq;
  assign status.invSts   = invSts;
  assign status.holdEn   = holdEn;
  assign status.lineBusy = busy;

  assign cmdValid = cmdValidQ;
  assign cmdOp    = cmdOpQ;
  assign txnHold  = holdEn && (evReq || invReq);

endmodule

// File: rtl/cmo_datapath.sv
module cmo_datapath
  import cmo_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int DATA_W = 32,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] wrLineAddr,
  input  logic [REG_AW-1:0] regRdAddr,
  input  ctlStrobe_t        strobe,
  input  ctlStatus_t        status,
  output logic [DATA_W-1:0] regRdData,
  output logic [LINE_W-1:0] cmdAddr
);

  localparam int NUM_KIND = 2;  // 0: evict, 1: invalidate

  logic [LINE_W-1:0] addrQ [NUM_KIND];
  logic [NUM_KIND-1:0] capVec;
  logic [LINE_W-1:0] cmdAddrQ;

  assign capVec = {strobe.capInval, strobe.capEvict};

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_lineAddr
    always_ff @(posedge clk) begin
      if (!rstN)          addrQ[k] <= '0;
      else if (capVec[k]) addrQ[k] <= wrLineAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdAddrQ <= '0;
    else if (strobe.issue) begin
      case (strobe.op)
        OP_EVICT_LINE: cmdAddrQ <= addrQ[0];
        OP_INVAL_LINE: cmdAddrQ <= addrQ[1];
        default:       cmdAddrQ <= '0;
      endcase
    end
  end

  assign cmdAddr = cmdAddrQ;

  always_comb begin
    regRdData = '0;
    case (regRdAddr)
      REG_AW'(OFS_CTRL): begin
        regRdData[BIT_EV_REQ]  = status.evReq;
        regRdData[BIT_EV_STS]  = status.evSts;
        regRdData[BIT_INV_REQ] = status.invReq;
        regRdData[BIT_INV_STS] = status.invSts;
        regRdData[BIT_HOLD]    = status.holdEn;
      end
      REG_AW'(OFS_EVICT_ADR): regRdData = DATA_W'(addrQ[0]);
      REG_AW'(OFS_INVAL_ADR): regRdData = DATA_W'(addrQ[1]);
      REG_AW'(OFS_BUSY):      regRdData[0] = status.lineBusy;
      default:                regRdData = '0;
    endcase
  end

endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
  import cmo_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int DATA_W = 32,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              cmdValid,
  output logic [1:0]        cmdOp,
  output logic [LINE_W-1:0] cmdAddr,
  input  logic              cmdDone,
  output logic              txnHold
);

  ctlStrobe_t ctlStb;
  ctlStatus_t ctlSts;
  cmoOp_t     opEnum;

  cmo_control #(.REG_AW(REG_AW)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .wrEvReqBit (regWrData[BIT_EV_REQ]),
    .wrInvReqBit(regWrData[BIT_INV_REQ]),
    .wrHoldBit  (regWrData[BIT_HOLD]),
    .cmdDone    (cmdDone),
    .strobe     (ctlStb),
    .status     (ctlSts),
    .cmdValid   (cmdValid),
    .cmdOp      (opEnum),
    .txnHold    (txnHold)
  );

  cmo_datapath #(.REG_AW(REG_AW), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrLineAddr(regWrData[LINE_W-1:0]),
    .regRdAddr (regRdAddr),
    .strobe    (ctlStb),
    .status    (ctlSts),
    .regRdData (regRdData),
    .cmdAddr   (cmdAddr)
  );

  assign cmdOp = opEnum;

endmodule

// File: rtl/cache_maint_ctrl_chk.sv
module cache_maint_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       cmdDone,
  input logic       txnHold,
  input logic       lineBusy,
  input logic       evReq,
  input logic       invReq,
  input logic       holdEn
);

  logic chkOut, chkLine, isLine;

  assign isLine = (cmdOp == 2'd2) || (cmdOp == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkOut  <= 1'b0;
      chkLine <= 1'b0;
    end else if (cmdValid) begin
      chkOut  <= 1'b1;
      chkLine <= isLine;
    end else if (cmdDone) begin
      chkOut <= 1'b0;
    end
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !chkOut);  // R8

  AST_LINE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && isLine) |-> lineBusy);  // R6

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && chkOut && chkLine && !cmdValid) |=> !lineBusy);  // R6

  AST_GLOBAL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && isLine) |-> $past(!evReq && !invReq));  // R9

  AST_HOLD_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !isLine && holdEn) |-> txnHold);  // R10

endmodule

bind cache_maint_ctrl cache_maint_ctrl_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .cmdOp   (cmdOp),
  .cmdDone (cmdDone),
  .txnHold (txnHold),
  .lineBusy(ctlSts.lineBusy),
  .evReq   (ctlSts.evReq),
  .invReq  (ctlSts.invReq),
  .holdEn  (ctlSts.holdEn)
);

// File: tb/test_cache_maint_ctrl.sv
module test_cache_maint_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int REG_AW = 8;
  localparam int DATA_W = 32;
  localparam int LINE_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [REG_AW-1:0] regWrAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [REG_AW-1:0] regRdAddr = '0;
  logic [DATA_W-1:0] regRdData;
  logic              cmdValid;
  logic [1:0]        cmdOp;
  logic [LINE_W-1:0] cmdAddr;
  logic              cmdDone = 1'b0;
  logic              txnHold;

  cache_maint_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W), .LINE_W(LINE_W)) i_cache_maint_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdDone(cmdDone), .txnHold(txnHold)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  logic [33:0] expQ [$];   // {op, addr}
  logic ackHold = 1'b1;
  int   ackDelay = 1;
  logic respBusy = 1'b0;
  int   ackCnt = 0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [31:0] exp, input string req);
    regRdAddr = a;
    #1;
    check(regRdData === exp, req, 64'(regRdData), 64'(exp));
  endtask

  task automatic push(input logic [1:0] op, input logic [31:0] addr);
    expQ.push_back({op, addr});
  endtask

  task automatic waitIdle();
    do begin
      @(negedge clk);
      #2;
    end while (expQ.size() != 0 || respBusy);
    repeat (2) @(negedge clk);
    #1;
  endtask

  // scoreboard monitor and cache responder
  always @(negedge clk) begin
    cmdDone = 1'b0;
    if (respBusy && !ackHold) begin
      if (ackCnt == 0) begin
        cmdDone = 1'b1;
        respBusy = 1'b0;
      end else ackCnt--;
    end
    if (rstN && cmdValid) begin
      if (respBusy) check(1'b0, "R8 strobe while outstanding", 64'(1), 64'(0));
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected command", 64'({cmdOp, cmdAddr}), 64'(0));
      end else begin
        logic [33:0] e;
        e = expQ.pop_front();
        check({cmdOp, cmdAddr} === e, "R4/R5/R9 command op,addr (R8)", 64'({cmdOp, cmdAddr}), 64'(e));
      end
      respBusy = 1'b1;
      ackCnt = ackDelay;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(0), 64'(1));
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    rdCheck(8'h0C, 32'h0001_0000, "R1 control word in reset");
    rdCheck(8'h18, 32'h0, "R1 busy in reset");
    check(cmdValid === 1'b0, "R1 no command in reset", 64'(cmdValid), 64'(0));
    push(2'd1, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R2: invalidate-all running after reset
    rdCheck(8'h0C, 32'h0011_0000, "R2 invalidate-all running");
    check(txnHold === 1'b0, "R10 no hold with hold bit clear", 64'(txnHold), 64'(0));
    ackHold = 1'b0;
    waitIdle();
    rdCheck(8'h0C, 32'h0, "R2 invalidate-all cleared by done");

    // R3 + R10: evict-all with hold enabled
    ackHold = 1'b1;
    push(2'd0, 32'h0);
    wr(8'h0C, 32'h0100_0001);
    check(txnHold === 1'b1, "R10 hold while evict-all pending", 64'(txnHold), 64'(1));
    rdCheck(8'h0C, 32'h0100_0001, "R3 evict-all requested");
    @(negedge clk);
    #1;
    rdCheck(8'h0C, 32'h0100_0011, "R3 evict-all running");
    ackHold = 1'b0;
    waitIdle();
    rdCheck(8'h0C, 32'h0100_0000, "R3 evict-all cleared by done");
    check(txnHold === 1'b0, "R10 hold released after done", 64'(txnHold), 64'(0));

    // R11: reserved and status bits
    wr(8'h0C, 32'hFEFE_FFFE);
    rdCheck(8'h0C, 32'h0, "R11 reserved/status bits ignore writes");
    rdCheck(8'h04, 32'h0, "R11 unmapped offset reads zero");
    rdCheck(8'h1C, 32'h0, "R11 unmapped offset reads zero");

    // R4, R6, R7: evict-line and writes while busy
    ackHold = 1'b1;
    push(2'd2, 32'hA5A5_0040);
    wr(8'h10, 32'hA5A5_0040);
    rdCheck(8'h18, 32'h1, "R6 busy after accepted write");
    @(negedge clk);
    #1;
    wr(8'h14, 32'h0000_1234);
    wr(8'h10, 32'hDEAD_0000);
    rdCheck(8'h10, 32'hA5A5_0040, "R7 evict address kept while busy");
    rdCheck(8'h14, 32'h0, "R7 invalidate address kept while busy");
    rdCheck(8'h18, 32'h1, "R6 busy while line command outstanding");
    ackHold = 1'b0;
    waitIdle();
    rdCheck(8'h18, 32'h0, "R6 busy cleared by done");

    // R5: invalidate-line with longer ack latency
    ackDelay = 3;
    push(2'd3, 32'h0000_1F80);
    wr(8'h14, 32'h0000_1F80);
    waitIdle();
    rdCheck(8'h14, 32'h0000_1F80, "R5 invalidate address stored");
    rdCheck(8'h18, 32'h0, "R6 busy cleared after invalidate-line");

    // R9: priority order with queued requests
    ackDelay = 1;
    ackHold = 1'b1;
    push(2'd0, 32'h0);
    wr(8'h0C, 32'h0000_0001);
    @(negedge clk);
    #1;
    wr(8'h14, 32'h0BAD_C0C0);
    wr(8'h0C, 32'h0001_0000);
    push(2'd1, 32'h0);
    push(2'd3, 32'h0BAD_C0C0);
    check(txnHold === 1'b0, "R10 no hold while hold bit clear", 64'(txnHold), 64'(0));
    rdCheck(8'h0C, 32'h0001_0011, "R9 both globals pending");
    ackHold = 1'b0;
    waitIdle();
    rdCheck(8'h0C, 32'h0, "R9 all globals done");
    rdCheck(8'h18, 32'h0, "R9 line done after globals");

    finishRun();
  end

endmodule